// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block holds one reservation for an atomic read-modify-write sequence. A load-linked request records the word address it read and arms the reservation. Two things disarm it before the matching conditional store arrives. One is a write by another processor or device to the same word, reported on a snoop port. The other is a return from an exception.

A conditional store is granted only while the reservation is armed and covers the same word. When it is granted, the block raises a one-cycle store enable toward memory. The block also returns a full-width result word for the store's source register: 1 on success, 0 on failure. Both kinds of request are checked for word alignment.

Requests are one per cycle. If a load-linked and a conditional store are presented together, the conditional store is the one that is taken. Every response is registered and appears in the cycle after the request.

Top module: `resv_monitor`

## Requirements
- R1: An aligned conditional store to the reserved word succeeds while the reservation is armed. In the next cycle `sc_done_o`=1, `sc_result_o`=1 and `mem_we_o`=1.
- R2: An exception-return pulse between the load-linked and the conditional store disarms the reservation, so that store fails. An exception return in the same cycle as the store also makes it fail.
- R3: A failing conditional store never raises `mem_we_o`.
- R4: `sc_done_o` pulses for one cycle for each aligned conditional store. In that cycle `sc_result_o` is 1 on success and 0 on failure; all its upper bits are always 0.
- R5: An address with bits [1:0] not equal to 00 on either request raises `addr_err_o` in the next cycle. A misaligned load-linked does not arm the reservation. A misaligned conditional store produces no `sc_done_o` and no `mem_we_o`, and leaves the reservation untouched.
- R6: Comparison is at word granularity, with address bits [1:0] ignored. A snooped write to any byte of the reserved word disarms the reservation. A snooped write to another word does not.
- R7: Every aligned conditional store disarms the reservation, whether it succeeds or fails.
- R8: A new aligned load-linked replaces the recorded word and arms the reservation again.
- R9: A conditional store to a word other than the reserved one fails.
- R10: A snooped write to the reserved word in the same cycle as the conditional store wins, and the store fails.
- R11: Synchronous reset disarms the reservation and clears all outputs.
- R12: A load-linked in the same cycle as a snooped write to its word, or as an exception return, still arms the reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ll_valid_i | input | 1 | Load-linked request |
| sc_valid_i | input | 1 | Conditional-store request |
| req_addr_i | input | AW | Physical byte address of the request |
| snoop_wr_i | input | 1 | Write by another agent observed |
| snoop_addr_i | input | AW | Byte address of the snooped write |
| eret_i | input | 1 | Exception-return pulse |
| sc_done_o | output | 1 | Conditional-store result is valid |
| sc_result_o | output | DW | Value for the source register (1 or 0) |
| mem_we_o | output | 1 | Store enable toward memory |
| addr_err_o | output | 1 | Address exception on the last request |

## Verification
On every cycle, the assertions check several things. A store enable is always paired with a done pulse and a result of 1. The upper result bits stay zero. A misaligned store is answered with an address error and no write. Any store that follows another store with no load-linked between them never writes. A same-cycle snoop to the reserved word blocks the write. An exception return always disarms the reservation. Only the bench's scenarios can show the rest of the behaviour, because it depends on the recorded address and on history: the byte-granular snoop match, a reservation replaced by a second load-linked, a reservation surviving a misaligned store, and the load-linked that arms despite a same-cycle snoop.

// File: rtl/resv_pkg.sv
package resv_pkg;

    localparam int OFFS_BITS = 2;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_LL   = 2'd1,
        REQ_SC   = 2'd2
    } req_kind_t;

    typedef struct packed {
        logic done;
        logic ok;
        logic err;
    } resv_resp_t;

    function automatic req_kind_t decode_req(input logic ll, input logic sc);
        if (sc)      return REQ_SC;
        else if (ll) return REQ_LL;
        else         return REQ_NONE;
    endfunction

    function automatic logic is_word_aligned(input logic [OFFS_BITS-1:0] lo);
        return (lo == '0);
    endfunction

endpackage

// File: rtl/resv_align_chk.sv
module resv_align_chk
    import resv_pkg::*;
#(
    parameter int AW = 32
) (
    input  req_kind_t        kind_i,
    input  logic [AW-1:0]    addr_i,
    output logic             ll_go_o,
    output logic             sc_go_o,
    output logic             err_o
);
    logic aligned;

    always_comb begin
        aligned = is_word_aligned(addr_i[OFFS_BITS-1:0]);
        ll_go_o = (kind_i == REQ_LL) && aligned;
        sc_go_o = (kind_i == REQ_SC) && aligned;
        err_o   = (kind_i != REQ_NONE) && !aligned;
    end
endmodule

// File: rtl/resv_store.sv
module resv_store
    import resv_pkg::*;
#(
    parameter int AW = 32,
    localparam int WW = AW - OFFS_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_i,
    input  logic          clear_i,
    input  logic [WW-1:0] req_word_i,
    input  logic          snoop_wr_i,
    input  logic [WW-1:0] snoop_word_i,
    input  logic          eret_i,
    output logic          armed_o,
    output logic [WW-1:0] word_o,
    output logic          snoop_hit_o
);
    logic          armed_q;
    logic [WW-1:0] word_q;

    assign snoop_hit_o = armed_q && snoop_wr_i && (snoop_word_i == word_q);
    assign armed_o     = armed_q;
    assign word_o      = word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            word_q  <= '0;
        end else if (set_i) begin
            armed_q <= 1'b1;
            word_q  <= req_word_i;
        end else if (clear_i || snoop_hit_o || eret_i) begin
            armed_q <= 1'b0;
        end
    end

    // R2: an exception return without a new load-linked leaves nothing armed
    p_eret_disarms_r2: assert property (@(posedge clk) disable iff (rst)
        (eret_i && !set_i) |=> !armed_q);

    // R12: an aligned load-linked arms whatever else happens that cycle
    p_ll_arms_r12: assert property (@(posedge clk) disable iff (rst)
        set_i |=> (armed_q && word_q == $past(req_word_i)));
endmodule

// File: rtl/resv_judge.sv
module resv_judge
    import resv_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int WW = AW - OFFS_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sc_go_i,
    input  logic          err_i,
    input  logic [WW-1:0] req_word_i,
    input  logic          armed_i,
    input  logic [WW-1:0] resv_word_i,
    input  logic          snoop_hit_i,
    input  logic          eret_i,
    output logic          sc_done_o,
    output logic [DW-1:0] sc_result_o,
    output logic          mem_we_o,
    output logic          addr_err_o
);
    resv_resp_t resp_d, resp_q;

    always_comb begin
        resp_d.done = sc_go_i;
        resp_d.ok   = sc_go_i && armed_i && (req_word_i == resv_word_i)
                      && !snoop_hit_i && !eret_i;
        resp_d.err  = err_i;
    end

    always_ff @(posedge clk) begin
        if (rst) resp_q <= '0;
        else     resp_q <= resp_d;
    end

    assign sc_done_o   = resp_q.done;
    assign mem_we_o    = resp_q.ok;
    assign addr_err_o  = resp_q.err;
    assign sc_result_o = {{(DW-1){1'b0}}, resp_q.ok};

    // R10: a same-cycle snoop hit on the reservation blocks the write
    p_snoop_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (sc_go_i && snoop_hit_i) |=> (sc_done_o && !mem_we_o));
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ll_valid_i,
    input  logic          sc_valid_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic          snoop_wr_i,
    input  logic [AW-1:0] snoop_addr_i,
    input  logic          eret_i,
    output logic          sc_done_o,
    output logic [DW-1:0] sc_result_o,
    output logic          mem_we_o,
    output logic          addr_err_o
);
    localparam int WW = AW - OFFS_BITS;

    req_kind_t     kind;
    logic          ll_go, sc_go, err;
    logic          armed, snoop_hit;
    logic [WW-1:0] resv_word;

    assign kind = decode_req(ll_valid_i, sc_valid_i);

    resv_align_chk #(.AW(AW)) align_i (
        .kind_i  (kind),
        .addr_i  (req_addr_i),
        .ll_go_o (ll_go),
        .sc_go_o (sc_go),
        .err_o   (err)
    );

    resv_store #(.AW(AW)) store_i (
        .clk          (clk),
        .rst          (rst),
        .set_i        (ll_go),
        .clear_i      (sc_go),
        .req_word_i   (req_addr_i[AW-1:OFFS_BITS]),
        .snoop_wr_i   (snoop_wr_i),
        .snoop_word_i (snoop_addr_i[AW-1:OFFS_BITS]),
        .eret_i       (eret_i),
        .armed_o      (armed),
        .word_o       (resv_word),
        .snoop_hit_o  (snoop_hit)
    );

    resv_judge #(.AW(AW), .DW(DW)) judge_i (
        .clk         (clk),
        .rst         (rst),
        .sc_go_i     (sc_go),
        .err_i       (err),
        .req_word_i  (req_addr_i[AW-1:OFFS_BITS]),
        .armed_i     (armed),
        .resv_word_i (resv_word),
        .snoop_hit_i (snoop_hit),
        .eret_i      (eret_i),
        .sc_done_o   (sc_done_o),
        .sc_result_o (sc_result_o),
        .mem_we_o    (mem_we_o),
        .addr_err_o  (addr_err_o)
    );

    // R3 / R1: a write only ever accompanies a successful, reported store
    p_we_means_success_r3: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> (sc_done_o && sc_result_o == DW'(1)));

    // R4: upper result bits stay zero
    p_result_narrow_r4: assert property (@(posedge clk) disable iff (rst)
        sc_result_o[DW-1:1] == '0);

    // R5: misaligned conditional store -> exception, no write, no done
    p_misalign_sc_r5: assert property (@(posedge clk) disable iff (rst)
        (sc_valid_i && req_addr_i[1:0] != 2'b00) |=> (addr_err_o && !mem_we_o && !sc_done_o));

    // R7: a second store with no load-linked in between never writes
    p_sc_consumes_r7: assert property (@(posedge clk) disable iff (rst)
        (sc_valid_i && req_addr_i[1:0] == 2'b00) ##1 (sc_valid_i && !ll_valid_i)
        |=> !mem_we_o);
endmodule

// File: tb/resv_monitor_tb_top.sv
`timescale 1ns/1ps
module resv_monitor_tb_top;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          ll_valid_i, sc_valid_i, snoop_wr_i, eret_i;
    logic [AW-1:0] req_addr_i, snoop_addr_i;
    logic          sc_done_o, mem_we_o, addr_err_o;
    logic [DW-1:0] sc_result_o;

    always #4 clk = ~clk;

    resv_monitor #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst(rst),
        .ll_valid_i(ll_valid_i), .sc_valid_i(sc_valid_i), .req_addr_i(req_addr_i),
        .snoop_wr_i(snoop_wr_i), .snoop_addr_i(snoop_addr_i), .eret_i(eret_i),
        .sc_done_o(sc_done_o), .sc_result_o(sc_result_o),
        .mem_we_o(mem_we_o), .addr_err_o(addr_err_o)
    );

    typedef struct {
        logic  done;
        logic  ok;
        logic  err;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 0;

    localparam logic [AW-1:0] A = 32'h0000_0100;
    localparam logic [AW-1:0] B = 32'h0000_0240;

    task automatic step(input bit ll, input bit sc, input logic [AW-1:0] a,
                        input bit sn, input logic [AW-1:0] sa, input bit er,
                        input bit rs, input bit e_done, input bit e_ok,
                        input bit e_err, input string tag);
        exp_t e;
        @(negedge clk);
        ll_valid_i   = ll;
        sc_valid_i   = sc;
        req_addr_i   = a;
        snoop_wr_i   = sn;
        snoop_addr_i = sa;
        eret_i       = er;
        rst          = rs;
        e.done = e_done; e.ok = e_ok; e.err = e_err; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(0, 0, '0, 0, '0, 0, 0, 0, 0, 0, tag);
    endtask

    // monitor: compare the registered response one step after each request
    always @(posedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [DW-1:0] exp_res;
            e = exp_q.pop_front();
            #1;
            exp_res = e.ok ? DW'(1) : '0;
            n_checks++;
            if (sc_done_o !== e.done || mem_we_o !== e.ok ||
                sc_result_o !== exp_res || addr_err_o !== e.err) begin
                n_errors++;
                $display("FAIL %s: got done=%b res=%0h we=%b err=%b, expected done=%b res=%0h we=%b err=%b",
                         e.tag, sc_done_o, sc_result_o, mem_we_o, addr_err_o,
                         e.done, exp_res, e.ok, e.err);
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        ll_valid_i = 0; sc_valid_i = 0; snoop_wr_i = 0; eret_i = 0;
        req_addr_i = '0; snoop_addr_i = '0; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        idle("R11 reset state");

        // R1/R4 basic success
        step(1, 0, A, 0, '0, 0, 0, 0, 0, 0, "R1 ll");
        step(0, 1, A, 0, '0, 0, 0, 1, 1, 0, "R1 R4 sc success");
        // R7 consumed, R3 no write
        step(0, 1, A, 0, '0, 0, 0, 1, 0, 0, "R7 R3 second sc fails");
        // R2 exception return between
        step(1, 0, A, 0, '0, 0, 0, 0, 0, 0, "R2 ll");
        step(0, 0, '0, 0, '0, 1, 0, 0, 0, 0, "R2 eret");
        step(0, 1, A, 0, '0, 0, 0, 1, 0, 0, "R2 sc after eret fails");
        // R2 same-cycle eret
        step(1, 0, A, 0, '0, 0, 0, 0, 0, 0, "R2 ll");
        step(0, 1, A, 0, '0, 1, 0, 1, 0, 0, "R2 sc with eret fails");
        // R6 snoop to a byte in reserved word
        step(1, 0, A, 0, '0, 0, 0, 0, 0, 0, "R6 ll");
        step(0, 0, '0, 1, A + 2, 0, 0, 0, 0, 0, "R6 snoop byte");
        step(0, 1, A, 0, '0, 0, 0, 1, 0, 0, "R6 sc after byte snoop fails");
        // R6 snoop to neighbouring word
        step(1, 0, A, 0, '0, 0, 0, 0, 0, 0, "R6 ll");
        step(0, 0, '0, 1, A + 4, 0, 0, 0, 0, 0, "R6 snoop other word");
        step(0, 1, A, 0, '0, 0, 0, 1, 1, 0, "R6 sc survives other snoop");
        // R9 address mismatch, then R7 cleared
        step(1, 0, A, 0, '0, 0, 0, 0, 0, 0, "R9 ll");
        step(0, 1, A + 8, 0, '0, 0, 0, 1, 0, 0, "R9 sc other word fails");
        step(0, 1, A, 0, '0, 0, 0, 1, 0, 0, "R7 failed sc cleared reservation");
        // R8 replacement
        step(1, 0, A, 0, '0, 0, 0, 0, 0, 0, "R8 ll A");
        step(1, 0, B, 0, '0, 0, 0, 0, 0, 0, "R8 ll B");
        step(0, 1, A, 0, '0, 0, 0, 1, 0, 0, "R8 sc old word fails");
        step(1, 0, A, 0, '0, 0, 0, 0, 0, 0, "R8 ll A");
        step(1, 0, B, 0, '0, 0, 0, 0, 0, 0, "R8 ll B");
        step(0, 1, B, 0, '0, 0, 0, 1, 1, 0, "R8 sc new word succeeds");
        // R10 same-cycle snoop wins
        step(1, 0, A, 0, '0, 0, 0, 0, 0, 0, "R10 ll");
        step(0, 1, A, 1, A + 3, 0, 0, 1, 0, 0, "R10 sc with snoop fails");
        // R5 misaligned ll
        step(1, 0, A + 1, 0, '0, 0, 0, 0, 0, 1, "R5 misaligned ll error");
        step(0, 1, A, 0, '0, 0, 0, 1, 0, 0, "R5 misaligned ll did not arm");
        // R5 misaligned sc leaves reservation
        step(1, 0, A, 0, '0, 0, 0, 0, 0, 0, "R5 ll");
        step(0, 1, A + 2, 0, '0, 0, 0, 0, 0, 1, "R5 misaligned sc error");
        step(0, 1, A, 0, '0, 0, 0, 1, 1, 0, "R5 reservation kept");
        // R11 reset disarms
        step(1, 0, A, 0, '0, 0, 0, 0, 0, 0, "R11 ll");
        step(0, 0, '0, 0, '0, 0, 1, 0, 0, 0, "R11 reset cycle");
        step(0, 1, A, 0, '0, 0, 0, 1, 0, 0, "R11 sc after reset fails");
        // R12 ll with same-cycle snoop / eret
        step(1, 0, A, 1, A, 0, 0, 0, 0, 0, "R12 ll with snoop");
        step(0, 1, A, 0, '0, 0, 0, 1, 1, 0, "R12 sc succeeds");
        step(1, 0, A, 0, '0, 1, 0, 0, 0, 0, "R12 ll with eret");
        step(0, 1, A, 0, '0, 0, 0, 1, 1, 0, "R12 sc succeeds");
        idle("R4 done is a pulse");
        idle("R4 idle");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule